// File: doc/BRIEF.md
# Coprocessor Multi-Word Transfer Responder

This block sits on the coprocessor side of a core/coprocessor handshake. It answers load-to-coprocessor and store-from-coprocessor instructions. Each cycle it returns a 2-bit response code to the core. An instruction it does not take is refused. An accepted instruction first holds the core in a busy-wait for as long as the coprocessor is not ready. It then issues one response per data word, and the final word is marked so that the core knows the transfer is ending.

The block keeps a small word-wide register bank. Store transfers read from this bank onto the outgoing data bus. Load transfers write incoming words into it. No register changes unless the core's pass line is high on a transfer cycle. If the pass line drops during busy-wait, the instruction is dropped and the block returns to idle, where it waits for the core to issue the instruction again.

Top module: `cpx_responder`

## Requirements
- R1: After reset, `hs_code` is 2'b00 (refused/idle), `data_out` is zero, and every bank word is zero.
- R2: A strobe on `instr_valid` with `instr_accept` low leaves the block idle, so `hs_code` stays 2'b00 on the following cycles. Strobes that arrive while an instruction is in progress are ignored.
- R3: Once an instruction is accepted, the code is 2'b01 (wait) on every cycle in which `not_ready` is high, for any number of cycles.
- R4: When `not_ready` is low, the code is 2'b10 (go) while two or more words remain and 2'b11 (last) when one word remains. An N-word transfer therefore shows N-1 committed go cycles and then one last cycle.
- R5: A single-word transfer shows zero or more wait cycles followed directly by last, with no go cycle.
- R6: A `word_count` of 0 is handled as a count of 1.
- R7: On a go or last cycle with `pass_ok` low, nothing is committed. The code, the word index and the bank all stay unchanged.
- R8: On a wait cycle with `pass_ok` low, the instruction is dropped. The code is 2'b00 on the next cycle and no bank word changes.
- R9: On go or last cycles of a store, `data_out` carries bank word number k, where k is the count of words already committed and starts at 0. On all other cycles `data_out` is zero.
- R10: On a committed load transfer (go or last with `pass_ok` high), `data_in` is written into bank word k. No other cycle writes the bank.
- R11: In the cycle after a committed last, the code is 2'b00. It stays 2'b00 until a new accepted strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | One-cycle strobe: a coprocessor transfer instruction is offered |
| instr_accept | input | 1 | Decode result: this coprocessor takes the instruction |
| instr_store | input | 1 | 1 = store (bank to core), 0 = load (core to bank) |
| word_count | input | CNT_W | Number of words to move; 0 is handled as 1 |
| not_ready | input | 1 | Coprocessor cannot proceed yet (forces wait) |
| pass_ok | input | 1 | Core confirms the instruction may commit |
| data_in | input | DATA_W | Word from the core on load transfers |
| hs_code | output | 2 | Response: 00 refused, 01 wait, 10 go, 11 last |
| data_out | output | DATA_W | Bank word on store transfer cycles, else zero |

## Verification
The hardest case to reach is a pass-line drop in the middle of a long busy-wait that comes after some words of the same instruction have already committed. Producing it needs a multi-word load, a change of `not_ready` back to high partway through, and a pass drop within that window. The bench randomises `not_ready` and `pass_ok` on every cycle over several phases with different probabilities, so these combinations occur many times. Because a behavioural model tracks every bank word and whether a load wrote it, later store transfers read back the result of each partial or aborted load.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

   typedef enum logic [1:0] {
      HS_ABSENT = 2'b00,
      HS_WAIT   = 2'b01,
      HS_GO     = 2'b10,
      HS_LAST   = 2'b11
   } hs_e;

endpackage

// File: rtl/cpx_seq.sv
module cpx_seq
   import cpx_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             instr_valid,
   input  logic             instr_accept,
   input  logic             instr_store,
   input  logic [CNT_W-1:0] word_count,
   input  logic             not_ready,
   input  logic             pass_ok,
   output hs_e              code,
   output logic [CNT_W-1:0] xfer_idx,
   output logic             wr_en,
   output logic             dout_en
);

   localparam logic [CNT_W-1:0] ONE_W = CNT_W'(1);

   logic             busy_q;
   logic             store_q;
   logic [CNT_W-1:0] rem_q;
   logic [CNT_W-1:0] idx_q;
   logic             commit;
   logic             start;

   assign start  = !busy_q && instr_valid && instr_accept;
   assign commit = busy_q && !not_ready && pass_ok;

   always_comb begin
      if (!busy_q)        code = HS_ABSENT;
      else if (not_ready) code = HS_WAIT;
      else if (rem_q == ONE_W) code = HS_LAST;
      else                code = HS_GO;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         store_q <= 1'b0;
         rem_q   <= '0;
         idx_q   <= '0;
      end else if (start) begin
         busy_q  <= 1'b1;
         store_q <= instr_store;
         rem_q   <= (word_count == '0) ? ONE_W : word_count;
         idx_q   <= '0;
      end else if (busy_q) begin
         if (not_ready && !pass_ok) begin
            busy_q <= 1'b0;
         end else if (commit) begin
            if (rem_q == ONE_W) begin
               busy_q <= 1'b0;
            end else begin
               rem_q <= rem_q - ONE_W;
               idx_q <= idx_q + ONE_W;
            end
         end
      end
   end

   assign xfer_idx = idx_q;
   assign wr_en    = commit && !store_q;
   assign dout_en  = busy_q && store_q && !not_ready;

   // R11
   last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code == HS_LAST && pass_ok) |=> code == HS_ABSENT);

   // R8
   wait_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code == HS_WAIT && !pass_ok) |=> code == HS_ABSENT);

   // R7
   hold_no_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((code == HS_GO || code == HS_LAST) && !pass_ok) |=>
         ($stable(rem_q) && $stable(idx_q) && busy_q));

   // R4
   go_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code == HS_GO && pass_ok) |=> (busy_q && idx_q == $past(idx_q) + ONE_W));

   // R2
   reject_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && instr_valid && !instr_accept) |=> code == HS_ABSENT);

endmodule

// File: rtl/cpx_regbank.sv
module cpx_regbank #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 2 ** IDX_W;

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             q <= '0;
         else if (we && idx == IDX_W'(g))        q <= wdata;
      end
      assign words[g] = q;
   end

   assign rdata = words[idx];

endmodule

// File: rtl/cpx_responder.sv
module cpx_responder
   import cpx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 4,
   parameter bit GATE_DOUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic              instr_accept,
   input  logic              instr_store,
   input  logic [CNT_W-1:0]  word_count,
   input  logic              not_ready,
   input  logic              pass_ok,
   input  logic [DATA_W-1:0] data_in,
   output logic [1:0]        hs_code,
   output logic [DATA_W-1:0] data_out
);

   if (DATA_W < 1 || DATA_W > 1024) begin : g_bad_data_w
      $error("cpx_responder: DATA_W out of range");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt_w
      $error("cpx_responder: CNT_W out of range");
   end

   hs_e               code;
   logic [CNT_W-1:0]  xfer_idx;
   logic              wr_en;
   logic              dout_en;
   logic [DATA_W-1:0] rd_word;

   cpx_seq #(.CNT_W(CNT_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .instr_valid  (instr_valid),
      .instr_accept (instr_accept),
      .instr_store  (instr_store),
      .word_count   (word_count),
      .not_ready    (not_ready),
      .pass_ok      (pass_ok),
      .code         (code),
      .xfer_idx     (xfer_idx),
      .wr_en        (wr_en),
      .dout_en      (dout_en)
   );

   cpx_regbank #(.DATA_W(DATA_W), .IDX_W(CNT_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .idx   (xfer_idx),
      .wdata (data_in),
      .rdata (rd_word)
   );

   assign hs_code = code;

   if (GATE_DOUT) begin : g_dout_gated
      assign data_out = dout_en ? rd_word : '0;
   end else begin : g_dout_raw
      assign data_out = rd_word;
   end

   // R10
   write_needs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (pass_ok && (hs_code == 2'b10 || hs_code == 2'b11)));

   // R3
   wait_when_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (not_ready && hs_code != 2'b00) |-> hs_code == 2'b01);

endmodule

// File: tb/tb_cpx_responder.sv
module tb_cpx_responder;

   localparam int DW = 32;
   localparam int CW = 4;
   localparam int NW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          instr_valid = 1'b0;
   logic          instr_accept = 1'b0;
   logic          instr_store = 1'b0;
   logic [CW-1:0] word_count = '0;
   logic          not_ready = 1'b0;
   logic          pass_ok = 1'b1;
   logic [DW-1:0] data_in = '0;
   logic [1:0]    hs_code;
   logic [DW-1:0] data_out;

   int vectors = 0;
   int fails = 0;

   // reference model state
   bit          m_busy = 0;
   bit          m_store = 0;
   bit          m_cnt0 = 0;
   int          m_rem = 0;
   int          m_total = 0;
   int          m_idx = 0;
   logic [DW-1:0] m_regs [NW];
   bit          m_from_load [NW];

   // stimulus knobs (percent)
   int p_valid = 30, p_accept = 80, p_nr = 20, p_drop = 10, cnt_max = 15;

   always #4 clk = ~clk;

   cpx_responder dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
      .instr_accept(instr_accept), .instr_store(instr_store),
      .word_count(word_count), .not_ready(not_ready), .pass_ok(pass_ok),
      .data_in(data_in), .hs_code(hs_code), .data_out(data_out)
   );

   task automatic check_code(input string tag, input logic [1:0] exp);
      vectors++;
      if (hs_code !== exp) begin
         fails++;
         $display("FAIL %s hs_code actual=%b expected=%b t=%0t", tag, hs_code, exp, $time);
      end
   endtask

   task automatic check_dout(input string tag, input logic [DW-1:0] exp);
      vectors++;
      if (data_out !== exp) begin
         fails++;
         $display("FAIL %s data_out actual=%h expected=%h t=%0t", tag, data_out, exp, $time);
      end
   endtask

   task automatic step();
      logic [1:0]    e_code;
      logic [DW-1:0] e_dout;
      string         tc, td;
      @(negedge clk);
      instr_valid  = ($urandom_range(0, 99) < p_valid);
      instr_accept = ($urandom_range(0, 99) < p_accept);
      instr_store  = $urandom_range(0, 1) == 1;
      word_count   = CW'($urandom_range(0, cnt_max));
      not_ready    = ($urandom_range(0, 99) < p_nr);
      pass_ok      = !($urandom_range(0, 99) < p_drop);
      data_in      = $urandom;
      #1;
      if (!m_busy)         e_code = 2'b00;
      else if (not_ready)  e_code = 2'b01;
      else if (m_rem == 1) e_code = 2'b11;
      else                 e_code = 2'b10;
      if (!m_busy)                    tc = (instr_valid && !instr_accept) ? "R2" : "R11";
      else if (not_ready)             tc = pass_ok ? "R3" : "R8";
      else if (!pass_ok)              tc = "R7";
      else if (m_cnt0)                tc = "R6";
      else if (m_total == 1)          tc = "R5";
      else                            tc = "R4";
      check_code(tc, e_code);
      if (m_busy && m_store && !not_ready) begin
         e_dout = m_regs[m_idx];
         td = m_from_load[m_idx] ? "R10" : "R9";
      end else begin
         e_dout = '0;
         td = "R9";
      end
      check_dout(td, e_dout);
      // advance model to the state after the coming edge
      if (!m_busy) begin
         if (instr_valid && instr_accept) begin
            m_busy  = 1;
            m_store = instr_store;
            m_cnt0  = (word_count == 0);
            m_rem   = (word_count == 0) ? 1 : int'(word_count);
            m_total = m_rem;
            m_idx   = 0;
         end
      end else if (not_ready && !pass_ok) begin
         m_busy = 0;
      end else if (!not_ready && pass_ok) begin
         if (!m_store) begin
            m_regs[m_idx]      = data_in;
            m_from_load[m_idx] = 1;
         end
         if (m_rem == 1) m_busy = 0;
         else begin
            m_rem--;
            m_idx++;
         end
      end
   endtask

   task automatic phase(input int n, input int pv, input int pa, input int pn,
                        input int pd, input int cm);
      p_valid = pv; p_accept = pa; p_nr = pn; p_drop = pd; cnt_max = cm;
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin : watchdog
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < NW; i++) begin
         m_regs[i] = '0;
         m_from_load[i] = 0;
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      check_code("R1", 2'b00);
      check_dout("R1", '0);
      @(negedge clk);
      rst_n = 1'b1;
      phase(200, 60, 0, 30, 10, 15);   // refusals only (R2)
      phase(1500, 30, 90, 10, 5, 15);  // mostly flowing multi-word
      phase(1500, 40, 90, 15, 10, 1);  // single word and count 0 (R5, R6)
      phase(3000, 30, 85, 45, 25, 15); // heavy waits and pass drops (R7, R8)
      phase(1500, 20, 90, 5, 2, 15);   // readback of loaded words (R9, R10)
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule